// File: doc/BRIEF.md
# Paged and Pointer-Register Data Address Generator

This block forms the data-memory address for a small signal processor core. It has two ways to form an address. In paged (direct) mode, a 7-bit offset taken from the instruction is placed under a one-bit page register. In register (indirect) mode, the address is the low byte of whichever of two 16-bit pointer registers is currently selected. A small selector register picks that pointer register.

During a register-mode access, the selected pointer register can be stepped up or down by one. The selector can also be rewritten in the same cycle. Both updates land at the clock edge that ends the access, so the address of the access itself comes from the old values. A modify-only request applies the same update without any data access.

The block also loads the pointer registers, the selector and the page register. It offers a read port from which the core stores a pointer register. It flags whether the selected register is non-zero, for loop branches. It marks any valid address that falls beyond the implemented RAM.

Top module: `dmem_addr_gen`

## Requirements
- R1: After reset the page register, the selector and both pointer registers are zero.
- R2: With `acc_en`=1 and `ind_mode`=0, `addr` equals {page, `dir_field`} (page in bit 7, offset in bits 6:0) and `addr_valid` is 1.
- R3: With `acc_en`=1 and `ind_mode`=1, `addr` equals bits 7:0 of the selected pointer register as it stood before this cycle's update.
- R4: On an update cycle, `step_sel`=01 adds one to the selected register and `step_sel`=10 subtracts one, wrapping modulo 2^16 over all 16 bits; 00 and 11 leave it unchanged.
- R5: On an update cycle with `ptr_chg`=1, the selector takes `ptr_new` at the closing clock edge, while that cycle's address still uses the old selector.
- R6: With `modify_en`=1, the step and selector change of R4/R5 are applied, and `addr_valid` stays 0 unless `acc_en` is also 1.
- R7: A paged-mode access (`acc_en`=1, `ind_mode`=0, `modify_en`=0) ignores `step_sel` and `ptr_chg`: the pointer registers and the selector keep their values.
- R8: `ld_kind` selects a load at the clock edge: 01 writes `ld_value` into the pointer register named by `ld_sel`, 10 writes `ld_value[0]` into the selector, and 11 writes `ld_value[0]` into the page register. 00 loads nothing.
- R9: A load wins over a same-cycle step on the same register, and a selector load wins over `ptr_chg`.
- R10: `ar_nz` is 1 exactly when the selected pointer register is non-zero.
- R11: `addr_oor` is 1 when `addr_valid` is 1 and `addr` is 144 or more, and is 0 otherwise.
- R12: `rd_data` returns the full 16-bit value of the pointer register named by `rd_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | A data access happens this cycle |
| modify_en | input | 1 | Apply the pointer update with no access |
| ind_mode | input | 1 | 1 selects register mode, 0 paged mode |
| dir_field | input | 7 | Instruction offset used in paged mode |
| step_sel | input | 2 | 00 hold, 01 increment, 10 decrement, 11 hold |
| ptr_chg | input | 1 | Rewrite the selector on this update |
| ptr_new | input | 1 | New selector value |
| ld_kind | input | 2 | 00 none, 01 pointer reg, 10 selector, 11 page |
| ld_sel | input | 1 | Pointer register targeted by a load |
| ld_value | input | 16 | Load data (memory word or immediate) |
| rd_sel | input | 1 | Pointer register shown on rd_data |
| addr | output | 8 | Data memory address |
| addr_valid | output | 1 | The address is used by an access |
| addr_oor | output | 1 | The valid address lies beyond the implemented RAM |
| rd_data | output | 16 | Value of the pointer register chosen by rd_sel |
| ar_nz | output | 1 | The selected pointer register is non-zero |
| ptr_o | output | 1 | Current selector |
| page_o | output | 1 | Current page register |

## Verification
The hardest case to reach is a single cycle that does three things at once. It reads through one register, steps that register and switches the selector to the other register. Only then can the bench tell a pre-update address from a post-update one. The stimulus first loads two pointer registers with distinct, recognisable low bytes. It then issues one register-mode access that combines a step with a selector change. It checks the address during the cycle, and afterwards reads each register back through the read port. The wrap corners are reached by loading 16'hFFFF and 16'h0000 directly, so they do not take thousands of steps. Load-versus-step collisions are reached by driving a load and an update to the same target in the same cycle.

// File: rtl/dmem_addr_pkg.sv
package dmem_addr_pkg;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'b00,
        STEP_INC  = 2'b01,
        STEP_DEC  = 2'b10,
        STEP_RSV  = 2'b11
    } step_e;

    typedef enum logic [1:0] {
        LD_NONE = 2'b00,
        LD_AUX  = 2'b01,
        LD_PTR  = 2'b10,
        LD_PAGE = 2'b11
    } ld_e;

endpackage

// File: rtl/dag_ar_next.sv
module dag_ar_next
    import dmem_addr_pkg::*;
#(
    parameter int AR_W  = 16,
    parameter int PTR_W = 1,
    parameter int IDX   = 0
) (
    input  logic [AR_W-1:0]  cur_val,
    input  logic [PTR_W-1:0] ptr_q,
    input  logic             upd_en,
    input  logic [1:0]       step_sel,
    input  logic             ld_hit,
    input  logic [AR_W-1:0]  ld_value,
    output logic [AR_W-1:0]  nxt_val
);
    localparam logic [PTR_W-1:0] MY_IDX = PTR_W'(IDX);
    localparam logic [AR_W-1:0]  ONE    = AR_W'(1);

    logic sel_me;
    assign sel_me = upd_en && (ptr_q == MY_IDX);

    always_comb begin
        nxt_val = cur_val;
        if (ld_hit) begin
            nxt_val = ld_value;
        end else if (sel_me) begin
            case (step_e'(step_sel))
                STEP_INC: nxt_val = cur_val + ONE;
                STEP_DEC: nxt_val = cur_val - ONE;
                default:  nxt_val = cur_val;
            endcase
        end
    end
endmodule

// File: rtl/dag_addr_form.sv
module dag_addr_form #(
    parameter int AR_W    = 16,
    parameter int ADDR_W  = 8,
    parameter int FIELD_W = 7
) (
    input  logic                      ind_mode,
    input  logic [ADDR_W-FIELD_W-1:0] page,
    input  logic [FIELD_W-1:0]        dir_field,
    input  logic [AR_W-1:0]           cur_ar,
    output logic [ADDR_W-1:0]         addr
);
    always_comb begin
        if (ind_mode) addr = cur_ar[ADDR_W-1:0];
        else          addr = {page, dir_field};
    end
endmodule

// File: rtl/dag_range_chk.sv
module dag_range_chk #(
    parameter int ADDR_W    = 8,
    parameter int RAM_WORDS = 144
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              valid,
    output logic              oor
);
    localparam int CMP_W = ADDR_W + 1;
    localparam logic [CMP_W-1:0] LIMIT = CMP_W'(RAM_WORDS);

    assign oor = valid && ({1'b0, addr} >= LIMIT);
endmodule

// File: rtl/dmem_addr_gen.sv
module dmem_addr_gen
    import dmem_addr_pkg::*;
#(
    parameter int AR_W      = 16,
    parameter int NUM_AR    = 2,
    parameter int ADDR_W    = 8,
    parameter int FIELD_W   = 7,
    parameter int RAM_WORDS = 144,
    localparam int PTR_W    = (NUM_AR > 1) ? $clog2(NUM_AR) : 1,
    localparam int PAGE_W   = ADDR_W - FIELD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_en,
    input  logic               modify_en,
    input  logic               ind_mode,
    input  logic [FIELD_W-1:0] dir_field,
    input  logic [1:0]         step_sel,
    input  logic               ptr_chg,
    input  logic [PTR_W-1:0]   ptr_new,
    input  logic [1:0]         ld_kind,
    input  logic [PTR_W-1:0]   ld_sel,
    input  logic [AR_W-1:0]    ld_value,
    input  logic [PTR_W-1:0]   rd_sel,
    output logic [ADDR_W-1:0]  addr,
    output logic               addr_valid,
    output logic               addr_oor,
    output logic [AR_W-1:0]    rd_data,
    output logic               ar_nz,
    output logic [PTR_W-1:0]   ptr_o,
    output logic [PAGE_W-1:0]  page_o
);
    typedef struct packed {
        logic [PAGE_W-1:0]             page;
        logic [PTR_W-1:0]              ptr;
        logic [NUM_AR-1:0][AR_W-1:0]   ar;
    } state_t;

    state_t st_q, st_d;

    logic                          upd_en;
    logic [AR_W-1:0]               cur_ar;
    logic [NUM_AR-1:0][AR_W-1:0]   ar_nxt;

    assign upd_en = modify_en || (acc_en && ind_mode);
    assign cur_ar = st_q.ar[st_q.ptr];

    for (genvar gi = 0; gi < NUM_AR; gi++) begin : g_ar
        logic ld_hit;
        assign ld_hit = (ld_e'(ld_kind) == LD_AUX) && (ld_sel == PTR_W'(gi));
        dag_ar_next #(
            .AR_W  (AR_W),
            .PTR_W (PTR_W),
            .IDX   (gi)
        ) u_next (
            .cur_val  (st_q.ar[gi]),
            .ptr_q    (st_q.ptr),
            .upd_en   (upd_en),
            .step_sel (step_sel),
            .ld_hit   (ld_hit),
            .ld_value (ld_value),
            .nxt_val  (ar_nxt[gi])
        );
    end

    dag_addr_form #(
        .AR_W    (AR_W),
        .ADDR_W  (ADDR_W),
        .FIELD_W (FIELD_W)
    ) u_form (
        .ind_mode  (ind_mode),
        .page      (st_q.page),
        .dir_field (dir_field),
        .cur_ar    (cur_ar),
        .addr      (addr)
    );

    assign addr_valid = acc_en;

    dag_range_chk #(
        .ADDR_W    (ADDR_W),
        .RAM_WORDS (RAM_WORDS)
    ) u_range (
        .addr  (addr),
        .valid (addr_valid),
        .oor   (addr_oor)
    );

    always_comb begin
        st_d    = st_q;
        st_d.ar = ar_nxt;
        if (upd_en && ptr_chg) st_d.ptr = ptr_new;
        case (ld_e'(ld_kind))
            LD_PTR:  st_d.ptr  = ld_value[PTR_W-1:0];
            LD_PAGE: st_d.page = ld_value[PAGE_W-1:0];
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.ar[rd_sel];
    assign ar_nz   = |cur_ar;
    assign ptr_o   = st_q.ptr;
    assign page_o  = st_q.page;
endmodule

// File: rtl/dmem_addr_chk.sv
module dmem_addr_chk #(
    parameter int AR_W    = 16,
    parameter int ADDR_W  = 8,
    parameter int FIELD_W = 7,
    parameter int PTR_W   = 1,
    parameter int PAGE_W  = 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               acc_en,
    input logic               modify_en,
    input logic               ind_mode,
    input logic [FIELD_W-1:0] dir_field,
    input logic [1:0]         step_sel,
    input logic               ptr_chg,
    input logic [PTR_W-1:0]   ptr_new,
    input logic [1:0]         ld_kind,
    input logic [PTR_W-1:0]   rd_sel,
    input logic [ADDR_W-1:0]  addr,
    input logic               addr_oor,
    input logic [AR_W-1:0]    rd_data,
    input logic               ar_nz,
    input logic [PTR_W-1:0]   ptr_o,
    input logic [PAGE_W-1:0]  page_o,
    input logic [AR_W-1:0]    cur_ar,
    input logic               upd_en
);
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (ptr_o == '0 && page_o == '0 && cur_ar == '0));

    p_direct_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !ind_mode) |-> (addr == {page_o, dir_field}));

    p_step_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && step_sel == 2'b01 && !ptr_chg && ld_kind == 2'b00)
        |=> (cur_ar == $past(cur_ar) + AR_W'(1)));

    p_ptr_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && ptr_chg && ld_kind != 2'b10) |=> (ptr_o == $past(ptr_new)));

    p_direct_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !ind_mode && !modify_en && ld_kind == 2'b00)
        |=> ($stable(ptr_o) && $stable(cur_ar)));

    p_nonzero_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == ptr_o) |-> (ar_nz == (rd_data != '0)));

    p_page0_in_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !ind_mode && page_o == '0) |-> !addr_oor);
endmodule

bind dmem_addr_gen dmem_addr_chk #(
    .AR_W    (AR_W),
    .ADDR_W  (ADDR_W),
    .FIELD_W (FIELD_W),
    .PTR_W   (PTR_W),
    .PAGE_W  (PAGE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_en    (acc_en),
    .modify_en (modify_en),
    .ind_mode  (ind_mode),
    .dir_field (dir_field),
    .step_sel  (step_sel),
    .ptr_chg   (ptr_chg),
    .ptr_new   (ptr_new),
    .ld_kind   (ld_kind),
    .rd_sel    (rd_sel),
    .addr      (addr),
    .addr_oor  (addr_oor),
    .rd_data   (rd_data),
    .ar_nz     (ar_nz),
    .ptr_o     (ptr_o),
    .page_o    (page_o),
    .cur_ar    (cur_ar),
    .upd_en    (upd_en)
);

// File: tb/dmem_addr_gen_tb.sv
module dmem_addr_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        acc_en, modify_en, ind_mode;
    logic [6:0]  dir_field;
    logic [1:0]  step_sel;
    logic        ptr_chg, ptr_new;
    logic [1:0]  ld_kind;
    logic        ld_sel;
    logic [15:0] ld_value;
    logic        rd_sel;
    logic [7:0]  addr;
    logic        addr_valid, addr_oor;
    logic [15:0] rd_data;
    logic        ar_nz, ptr_o, page_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    dmem_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .modify_en(modify_en),
        .ind_mode(ind_mode), .dir_field(dir_field), .step_sel(step_sel),
        .ptr_chg(ptr_chg), .ptr_new(ptr_new), .ld_kind(ld_kind), .ld_sel(ld_sel),
        .ld_value(ld_value), .rd_sel(rd_sel), .addr(addr), .addr_valid(addr_valid),
        .addr_oor(addr_oor), .rd_data(rd_data), .ar_nz(ar_nz), .ptr_o(ptr_o),
        .page_o(page_o)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        acc_en = 0; modify_en = 0; ind_mode = 0; dir_field = '0; step_sel = 2'b00;
        ptr_chg = 0; ptr_new = 0; ld_kind = 2'b00; ld_sel = 0; ld_value = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic do_load(logic [1:0] kind, logic sel, logic [15:0] val);
        idle();
        ld_kind = kind; ld_sel = sel; ld_value = val;
        tick();
        idle();
    endtask

    task automatic read_ar(string req, logic sel, logic [15:0] exp);
        rd_sel = sel;
        #1;
        chk(req, "rd_data", rd_data, exp);
    endtask

    task automatic t_reset();
        read_ar("R1", 1'b0, 16'h0000);
        read_ar("R1", 1'b1, 16'h0000);
        chk("R1", "ptr_o", ptr_o, 0);
        chk("R1", "page_o", page_o, 0);
        chk("R10", "ar_nz after reset", ar_nz, 0);
    endtask

    task automatic t_loads();
        do_load(2'b01, 1'b0, 16'h1234);
        do_load(2'b01, 1'b1, 16'h00A0);
        do_load(2'b11, 1'b0, 16'h0001);
        do_load(2'b10, 1'b0, 16'h0001);
        read_ar("R8 R12", 1'b0, 16'h1234);
        read_ar("R8 R12", 1'b1, 16'h00A0);
        chk("R8", "page_o", page_o, 1);
        chk("R8", "ptr_o", ptr_o, 1);
        chk("R10", "ar_nz with AR1 selected", ar_nz, 1);
    endtask

    task automatic t_direct();
        idle();
        acc_en = 1; dir_field = 7'h05;
        #1;
        chk("R2", "addr page1", addr, 8'h85);
        chk("R2", "addr_valid", addr_valid, 1);
        chk("R11", "oor at 133", addr_oor, 0);
        dir_field = 7'h10;
        #1;
        chk("R11", "oor at 144", addr_oor, 1);
        dir_field = 7'h0F;
        #1;
        chk("R11", "oor at 143", addr_oor, 0);
        tick();
        do_load(2'b11, 1'b0, 16'h0000);
        acc_en = 1; dir_field = 7'h7F;
        #1;
        chk("R2", "addr page0", addr, 8'h7F);
        acc_en = 0;
        #1;
        chk("R11", "oor without access", addr_oor, 0);
        idle();
    endtask

    task automatic t_indirect();
        idle();
        acc_en = 1; ind_mode = 1; step_sel = 2'b01; ptr_chg = 1; ptr_new = 0;
        #1;
        chk("R3", "addr from AR1", addr, 8'hA0);
        chk("R11", "oor at 160", addr_oor, 1);
        tick();
        idle();
        read_ar("R4", 1'b1, 16'h00A1);
        chk("R5", "ptr_o after change", ptr_o, 0);
        acc_en = 1; ind_mode = 1;
        #1;
        chk("R3", "low byte of AR0", addr, 8'h34);
        chk("R11", "oor at 52", addr_oor, 0);
        tick();
        idle();
        read_ar("R4", 1'b0, 16'h1234);
    endtask

    task automatic t_wrap();
        do_load(2'b01, 1'b0, 16'hFFFF);
        acc_en = 1; ind_mode = 1; step_sel = 2'b01;
        tick();
        idle();
        read_ar("R4", 1'b0, 16'h0000);
        chk("R10", "ar_nz zero", ar_nz, 0);
        acc_en = 1; ind_mode = 1; step_sel = 2'b10;
        #1;
        chk("R3", "pre-update addr", addr, 8'h00);
        tick();
        idle();
        read_ar("R4", 1'b0, 16'hFFFF);
        acc_en = 1; ind_mode = 1; step_sel = 2'b11;
        tick();
        idle();
        read_ar("R4", 1'b0, 16'hFFFF);
    endtask

    task automatic t_modify();
        do_load(2'b01, 1'b0, 16'h0005);
        modify_en = 1; step_sel = 2'b10; ptr_chg = 1; ptr_new = 1;
        #1;
        chk("R6", "addr_valid on modify", addr_valid, 0);
        chk("R6", "oor on modify", addr_oor, 0);
        tick();
        idle();
        read_ar("R6", 1'b0, 16'h0004);
        chk("R6", "ptr_o after modify", ptr_o, 1);
    endtask

    task automatic t_direct_ignore();
        acc_en = 1; ind_mode = 0; step_sel = 2'b01; ptr_chg = 1; ptr_new = 0;
        tick();
        idle();
        chk("R7", "ptr_o kept", ptr_o, 1);
        read_ar("R7", 1'b1, 16'h00A1);
        read_ar("R7", 1'b0, 16'h0004);
    endtask

    task automatic t_load_wins();
        do_load(2'b10, 1'b0, 16'h0000);
        do_load(2'b01, 1'b0, 16'h0010);
        acc_en = 1; ind_mode = 1; step_sel = 2'b01;
        ld_kind = 2'b01; ld_sel = 0; ld_value = 16'h0077;
        tick();
        idle();
        read_ar("R9", 1'b0, 16'h0077);
        acc_en = 1; ind_mode = 1; ptr_chg = 1; ptr_new = 1;
        ld_kind = 2'b10; ld_value = 16'h0000;
        tick();
        idle();
        chk("R9", "ptr load beats change", ptr_o, 0);
    endtask

    task automatic t_nonzero();
        do_load(2'b01, 1'b0, 16'h0000);
        #1;
        chk("R10", "ar_nz AR0 zero", ar_nz, 0);
        do_load(2'b10, 1'b0, 16'h0001);
        #1;
        chk("R10", "ar_nz AR1 nonzero", ar_nz, 1);
        do_load(2'b01, 1'b1, 16'h0100);
        #1;
        chk("R10", "ar_nz high byte only", ar_nz, 1);
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        idle();
        rd_sel = 0;
        rst_n  = 0;
        repeat (3) tick();
        rst_n = 1;
        tick();
        t_reset();
        t_loads();
        t_direct();
        t_indirect();
        t_wrap();
        t_modify();
        t_direct_ignore();
        t_load_wins();
        t_nonzero();
        report();
    end

    initial begin
        #200000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end
endmodule